// File: doc/BRIEF.md
# DFI Software Command Injector

This block sits between a DRAM controller and the DFI command port of a PHY. A bus master can use it to take over the phase-0 command pins and send single DRAM commands by hand. That is the usual way to bring a memory up: release reset, raise the clock enable, program the mode registers and start ZQ calibration. When setup is done, the master hands the pins back to the controller.

Software works through a small register file on a 32-bit bus slave with Wishbone-style handshaking. It sets the chip select, RAS, CAS and WE requests one bit at a time, loads the address and bank, then fires the command with a one-shot write. A control register holds the clock enable, on-die termination and DRAM reset levels. The same register holds an ownership bit that routes the controller's own DFI signals straight to the outputs.

The bus address is a word index, which is the byte offset divided by four. The decoded word indices are:

| Word | Byte offset | Register |
|------|-------------|----------|
| 0 | 0x00 | control |
| 1 | 0x04 | command |
| 2 | 0x08 | issue |
| 3 | 0x0C | address |
| 4 | 0x10 | bank |

Top module: `dfi_cmd_injector`

## Requirements
- R1: After reset the control register is 0. While software owns the pins, this gives `dfi_reset_n`=0, `dfi_cke`=0, `dfi_odt`=0, `dfi_cs_n`=1, and an address and bank of 0.
- R2: `bus_ack` rises for exactly one cycle, in the cycle after a clock edge at which `bus_cyc` and `bus_stb` were high and `bus_ack` was low. Writes take effect at that same edge.
- R3: With control bit 0 clear, control bit 1 drives `dfi_cke`, bit 2 drives `dfi_odt` and bit 3 drives `dfi_reset_n`.
- R4: Writing 1 in bit 0 of word 2 (issue) drives the stored command for exactly one cycle. That cycle is the one in which the write is acknowledged. Command bit 0 pulls `dfi_cs_n` low, bit 1 pulls `dfi_we_n` low, bit 2 pulls `dfi_cas_n` low and bit 3 pulls `dfi_ras_n` low. So 0x0F gives mode-register-set and 0x03 gives ZQ calibration.
- R5: In every other software-owned cycle, `dfi_cs_n`, `dfi_ras_n`, `dfi_cas_n` and `dfi_we_n` are all high (NOP).
- R6: With control bit 0 clear, `dfi_address` shows word 3 and `dfi_bank` shows word 4. Both stay stable except after a bus write.
- R7: With control bit 0 set, every DFI output equals the matching `ctl_*` input in the same cycle.
- R8: A read returns its data with the ack. Words 0, 1, 3 and 4 return their stored fields, zero-extended: 4, 4, ADDR_W and BANK_W bits. Word 2 and unmapped words read 0.
- R9: Writing word 2 with bit 0 at 0 fires nothing. A write to an unmapped word is acknowledged but changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_adr | input | REG_AW | Word index of the register |
| bus_dat_w | input | 32 | Write data |
| bus_dat_r | output | 32 | Read data, valid with ack |
| bus_we | input | 1 | Write enable |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Cycle valid |
| bus_ack | output | 1 | One-cycle acknowledge |
| ctl_cs_n | input | 1 | Controller chip select |
| ctl_ras_n | input | 1 | Controller RAS |
| ctl_cas_n | input | 1 | Controller CAS |
| ctl_we_n | input | 1 | Controller WE |
| ctl_address | input | ADDR_W | Controller address |
| ctl_bank | input | BANK_W | Controller bank |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_odt | input | 1 | Controller termination |
| ctl_reset_n | input | 1 | Controller DRAM reset |
| dfi_cs_n | output | 1 | Chip select to PHY |
| dfi_ras_n | output | 1 | RAS to PHY |
| dfi_cas_n | output | 1 | CAS to PHY |
| dfi_we_n | output | 1 | WE to PHY |
| dfi_address | output | ADDR_W | Address to PHY |
| dfi_bank | output | BANK_W | Bank to PHY |
| dfi_cke | output | 1 | Clock enable to PHY |
| dfi_odt | output | 1 | Termination to PHY |
| dfi_reset_n | output | 1 | DRAM reset to PHY |

## Verification
The assertions assume a master that drops `bus_stb` in the cycle it sees `bus_ack`, and never asks for a new access in that same cycle. Under that assumption, two issue pulses can never land on adjacent cycles. The bench's bus tasks keep to this rule: they raise the strobe one cycle, wait for the ack, and then release it. The `ctl_*` inputs are free-running values that the bench changes only between bus accesses. This lets the pass-through check compare same-cycle values.

// File: rtl/dfi_cmd_injector.sv
module dfi_cmd_injector #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_adr,
  input  logic [31:0]       bus_dat_w,
  output logic [31:0]       bus_dat_r,
  input  logic              bus_we,
  input  logic              bus_stb,
  input  logic              bus_cyc,
  output logic              bus_ack,
  input  logic              ctl_cs_n,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic [ADDR_W-1:0] ctl_address,
  input  logic [BANK_W-1:0] ctl_bank,
  input  logic              ctl_cke,
  input  logic              ctl_odt,
  input  logic              ctl_reset_n,
  output logic              dfi_cs_n,
  output logic              dfi_ras_n,
  output logic              dfi_cas_n,
  output logic              dfi_we_n,
  output logic [ADDR_W-1:0] dfi_address,
  output logic [BANK_W-1:0] dfi_bank,
  output logic              dfi_cke,
  output logic              dfi_odt,
  output logic              dfi_reset_n
);

  localparam logic [REG_AW-1:0] W_CTRL  = REG_AW'(0);
  localparam logic [REG_AW-1:0] W_CMD   = REG_AW'(1);
  localparam logic [REG_AW-1:0] W_ISSUE = REG_AW'(2);
  localparam logic [REG_AW-1:0] W_ADDR  = REG_AW'(3);
  localparam logic [REG_AW-1:0] W_BANK  = REG_AW'(4);

  logic [3:0]        ctrl_q, cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              fire_q, ack_q;
  logic [31:0]       rdat_q, rd_mux;

  wire accept = bus_cyc & bus_stb & ~ack_q;
  wire wr     = accept & bus_we;
  wire hw_own = ctrl_q[0];

  logic unused_dat;
  assign unused_dat = &{1'b0, bus_dat_w[31:ADDR_W]};

  always_comb begin
    case (bus_adr)
      W_CTRL:  rd_mux = 32'(ctrl_q);
      W_CMD:   rd_mux = 32'(cmd_q);
      W_ADDR:  rd_mux = 32'(addr_q);
      W_BANK:  rd_mux = 32'(bank_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      bank_q <= '0;
      fire_q <= 1'b0;
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= accept;
      fire_q <= wr && (bus_adr == W_ISSUE) && bus_dat_w[0];
      if (accept && !bus_we) rdat_q <= rd_mux;
      if (wr) begin
        case (bus_adr)
          W_CTRL:  ctrl_q <= bus_dat_w[3:0];
          W_CMD:   cmd_q  <= bus_dat_w[3:0];
          W_ADDR:  addr_q <= bus_dat_w[ADDR_W-1:0];
          W_BANK:  bank_q <= bus_dat_w[BANK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_dat_r = rdat_q;

  assign dfi_cs_n    = hw_own ? ctl_cs_n    : ~(fire_q & cmd_q[0]);
  assign dfi_we_n    = hw_own ? ctl_we_n    : ~(fire_q & cmd_q[1]);
  assign dfi_cas_n   = hw_own ? ctl_cas_n   : ~(fire_q & cmd_q[2]);
  assign dfi_ras_n   = hw_own ? ctl_ras_n   : ~(fire_q & cmd_q[3]);
  assign dfi_address = hw_own ? ctl_address : addr_q;
  assign dfi_bank    = hw_own ? ctl_bank    : bank_q;
  assign dfi_cke     = hw_own ? ctl_cke     : ctrl_q[1];
  assign dfi_odt     = hw_own ? ctl_odt     : ctrl_q[2];
  assign dfi_reset_n = hw_own ? ctl_reset_n : ctrl_q[3];

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R2
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(bus_cyc && bus_stb)); // R2
  AST_CMD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_own && !dfi_cs_n) |-> bus_ack); // R4
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_own && !dfi_cs_n) |=> (hw_own || dfi_cs_n)); // R4
  AST_NOP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_own && !bus_ack) |-> (dfi_cs_n && dfi_ras_n && dfi_cas_n && dfi_we_n)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_own && $past(!hw_own) && !$past(wr)) |-> ($stable(dfi_address) && $stable(dfi_bank))); // R6

endmodule

// File: tb/dfi_cmd_injector_test.sv
`timescale 1ns/1ps
module dfi_cmd_injector_test;
  localparam int AW = 16, BW = 3, RW = 3;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] adr = '0;
  logic [31:0] dat_w = '0, dat_r;
  logic we = 0, stb = 0, cyc = 0, ack;
  logic c_cs = 0, c_ras = 1, c_cas = 0, c_we = 1, c_cke = 1, c_odt = 0, c_rst = 1;
  logic [AW-1:0] c_addr = 16'hBEEF;
  logic [BW-1:0] c_bank = 3'd5;
  logic cs_n, ras_n, cas_n, we_n, cke, odt, rstn_o;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] bank_o;

  always #2.5 clk = ~clk;

  dfi_cmd_injector #(.ADDR_W(AW), .BANK_W(BW), .REG_AW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_adr(adr), .bus_dat_w(dat_w), .bus_dat_r(dat_r),
    .bus_we(we), .bus_stb(stb), .bus_cyc(cyc), .bus_ack(ack),
    .ctl_cs_n(c_cs), .ctl_ras_n(c_ras), .ctl_cas_n(c_cas), .ctl_we_n(c_we),
    .ctl_address(c_addr), .ctl_bank(c_bank), .ctl_cke(c_cke), .ctl_odt(c_odt),
    .ctl_reset_n(c_rst),
    .dfi_cs_n(cs_n), .dfi_ras_n(ras_n), .dfi_cas_n(cas_n), .dfi_we_n(we_n),
    .dfi_address(addr_o), .dfi_bank(bank_o), .dfi_cke(cke), .dfi_odt(odt),
    .dfi_reset_n(rstn_o));

  int vectors = 0, misses = 0;
  bit running = 0, done = 0;

  int m_ctrl, m_cmd, m_addr, m_bank, m_rdat;
  bit m_ack, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cmd = 0; m_addr = 0; m_bank = 0; m_rdat = 0; m_ack = 0; m_fire = 0;
    end else begin
      m_fire = 0;
      if (cyc && stb && !m_ack) begin
        m_ack = 1;
        if (we) begin
          case (int'(adr))
            0: m_ctrl = dat_w & 32'hF;
            1: m_cmd  = dat_w & 32'hF;
            2: m_fire = dat_w[0];
            3: m_addr = dat_w & ((1 << AW) - 1);
            4: m_bank = dat_w & ((1 << BW) - 1);
            default: ;
          endcase
        end else begin
          case (int'(adr))
            0: m_rdat = m_ctrl;
            1: m_rdat = m_cmd;
            3: m_rdat = m_addr;
            4: m_rdat = m_bank;
            default: m_rdat = 0;
          endcase
        end
      end else m_ack = 0;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    bit hw, p;
    hw = m_ctrl[0];
    p = m_fire;
    chk("R2", "ack", ack, m_ack);
    if (ack && !we) chk("R8", "rdata", dat_r, m_rdat);
    if (hw) begin
      chk("R7", "pins", {cs_n, ras_n, cas_n, we_n, cke, odt, rstn_o, addr_o, bank_o},
          {c_cs, c_ras, c_cas, c_we, c_cke, c_odt, c_rst, c_addr, c_bank});
    end else begin
      chk("R4", "cmd", {cs_n, we_n, cas_n, ras_n},
          {!(p && m_cmd[0]), !(p && m_cmd[1]), !(p && m_cmd[2]), !(p && m_cmd[3])});
      chk("R3", "ctl", {cke, odt, rstn_o}, {m_ctrl[1], m_ctrl[2], m_ctrl[3]});
      chk("R6", "addr", {addr_o, bank_o}, {m_addr[AW-1:0], m_bank[BW-1:0]});
    end
  end

  task automatic access(input int a, input bit w, input logic [31:0] d, output logic [31:0] q);
    @(posedge clk); #1;
    adr = RW'(a); dat_w = d; we = w; stb = 1; cyc = 1;
    do begin @(posedge clk); #1; end while (!ack);
    q = dat_r;
    stb = 0; cyc = 0; we = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [31:0] q;
    access(a, 1, d, q);
  endtask

  task automatic rd(input int a, output logic [31:0] q);
    access(a, 0, 32'h0, q);
  endtask

  initial begin
    logic [31:0] q;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;
    @(negedge clk);
    chk("R1", "reset pins", {rstn_o, cke, odt, cs_n, addr_o, bank_o}, {4'b0001, 19'h0});

    wr(3, 32'h0); wr(4, 32'h0);
    wr(0, 32'h0C);
    chk("R3", "reset released", {rstn_o, odt, cke}, 3'b110);
    wr(0, 32'h0E);
    chk("R3", "cke up", cke, 1);

    wr(3, 32'h200); wr(4, 32'h2);
    chk("R6", "mrs addr", {addr_o, bank_o}, {16'h200, 3'd2});
    wr(1, 32'h0F);
    wr(2, 32'h1);
    chk("R4", "mrs pulse", {cs_n, ras_n, cas_n, we_n}, 4'b0000);
    @(posedge clk); #1;
    chk("R5", "nop after mrs", {cs_n, ras_n, cas_n, we_n}, 4'b1111);

    wr(3, 32'h400); wr(4, 32'h0); wr(1, 32'h03); wr(2, 32'h1);
    chk("R4", "zq pulse", {cs_n, we_n, cas_n, ras_n}, 4'b0011);
    @(posedge clk); #1;
    chk("R5", "nop after zq", {cs_n, ras_n, cas_n, we_n}, 4'b1111);

    wr(2, 32'h0);
    chk("R9", "issue zero no pulse", cs_n, 1);
    wr(5, 32'hFFFF_FFFF);
    wr(7, 32'h0000_0001);
    rd(0, q); chk("R9", "ctrl after unmapped", q, 32'h0E);
    rd(1, q); chk("R8", "cmd read", q, 32'h03);
    rd(3, q); chk("R9", "addr after unmapped", q, 32'h400);
    rd(2, q); chk("R8", "issue reads zero", q, 0);
    rd(6, q); chk("R8", "unmapped reads zero", q, 0);
    wr(4, 32'hFFFF_FFFF);
    rd(4, q); chk("R8", "bank width", q, 32'h7);
    wr(3, 32'h1234_ABCD);
    rd(3, q); chk("R8", "addr width", q, 32'hABCD);

    wr(0, 32'h01);
    @(negedge clk);
    chk("R7", "pass addr", {addr_o, cs_n, cke}, {16'hBEEF, 1'b0, 1'b1});
    c_addr = 16'h0F0F; c_cs = 1; c_cke = 0; c_bank = 3'd1;
    @(negedge clk);
    chk("R7", "pass follow", {addr_o, bank_o, cs_n, cke}, {16'h0F0F, 3'd1, 1'b1, 1'b0});
    c_cs = 0;
    wr(2, 32'h1);
    chk("R7", "issue while owned", cs_n, 0);
    c_cs = 1;
    wr(0, 32'h0A);
    @(negedge clk);
    chk("R5", "back to nop", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk("R3", "back to regs", {rstn_o, odt, cke}, 3'b101);

    wr(0, 32'h00);
    @(negedge clk);
    chk("R1", "dram held", {rstn_o, cke}, 2'b00);

    repeat (4) @(posedge clk);
    running = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule